// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block sits on the write side of a byte-wide flash controller. It watches every bus write (address and data byte) headed for the device and recognises the multi-cycle unlock commands. Every command opens with the same two keyed writes. From there the decoder either finishes a 3-cycle command or goes on to a 6-cycle command. Its outputs tell the page-program engine when software protection changes, when a chip erase must start and when a page-load window is open. They also tell the read multiplexer when identification codes must replace array data.

The software-protection flag sits in a register that the reset input never touches. It powers up set. While the flag is set, an ordinary data write is thrown away unless the enable command has opened a load window first. While it is clear, any ordinary data write is passed on and opens a window by itself. A window stays open until the page engine reports that the load phase has ended. While the window is open, every write is passed through as page data and no command matching takes place.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a clock edge with `rst_n` low, `id_mode`, `load_open`, `fwd_valid` and `erase_go` are 0 and the sequence tracker is idle.
- R2: `prot_on` is 1 from power-up, and `rst_n` never changes it.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set `prot_on` and `load_open` at the edge that samples the third write. None of the three writes appears on the forward port.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear `prot_on` at the edge that samples the sixth write.
- R5: The same 6-cycle form ending in 10h@5555h makes `erase_go` high for exactly one cycle, after the edge that samples the sixth write.
- R6: `id_mode` is set by the 3-cycle form ending in 90h@5555h or by the 6-cycle form ending in 60h@5555h. It is cleared by the 3-cycle form ending in F0h@5555h and by `rst_n` low.
- R7: `id_data` is a combinational function of `rd_addr`. With `id_mode` = 1 it gives DAh for address 0, C8h for address 1 and 00h for any other address. With `id_mode` = 0 it is 00h.
- R8: While `prot_on` = 1 and `load_open` = 0, a write that no command consumes is discarded, and `fwd_valid` stays 0.
- R9: While `load_open` = 1, every write appears on `fwd_valid`/`fwd_addr`/`fwd_data` one edge later, with no command matching. `page_closed` high at an edge closes the window after that edge.
- R10: While `prot_on` = 0 and `load_open` = 0, a write that no command consumes is forwarded and sets `load_open`.
- R11: Only address bits 14..0 take part in matching, so D555h/AAAAh match like 5555h/2AAAh.
- R12: A write that does not continue the current sequence returns the tracker to idle and is handled as a data write. If that write is AAh@5555h, it instead starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (protection flag excluded) |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| page_closed | input | 1 | Page engine ends the current load window |
| rd_addr | input | ADDR_W | Read address for identification codes |
| prot_on | output | 1 | Software protection flag |
| id_mode | output | 1 | Identification read mode active |
| erase_go | output | 1 | One-cycle chip-erase start pulse |
| load_open | output | 1 | Page-load window open |
| fwd_valid | output | 1 | Forwarded data write valid |
| fwd_addr | output | ADDR_W | Forwarded write address |
| fwd_data | output | 8 | Forwarded write data |
| id_data | output | 8 | Identification byte for the read multiplexer |

## Verification
All registered results (`prot_on`, `id_mode`, `erase_go`, `load_open` and the forward port) are due at the single rising edge that samples the deciding write, with no extra pipeline stage. `id_data` follows `rd_addr` and `id_mode` within the same cycle. The bench drives each write after a falling edge and advances its behavioural model by one step for that write. It then compares every output at the next falling edge, one edge after the write. A one-cycle pulse such as `erase_go` is therefore checked high in exactly that sample and low in the following one.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    // Unlock key addresses (compared on the low match bits only)
    localparam int unsigned KEY_ADDR_1 = 32'h5555;
    localparam int unsigned KEY_ADDR_2 = 32'h2AAA;

    // Key and operation bytes
    localparam logic [7:0] KEY_BYTE_1  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_2  = 8'h55;
    localparam logic [7:0] OP_PROT_SET = 8'hA0;
    localparam logic [7:0] OP_EXTEND   = 8'h80;
    localparam logic [7:0] OP_ID_SHORT = 8'h90;
    localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
    localparam logic [7:0] OP_PROT_CLR = 8'h20;
    localparam logic [7:0] OP_ERASE    = 8'h10;
    localparam logic [7:0] OP_ID_LONG  = 8'h60;

    // Progress through a command: K1/K2 first key pair, EXT after 80h, K4/K5 second key pair
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_K1   = 3'd1,
        SQ_K2   = 3'd2,
        SQ_EXT  = 3'd3,
        SQ_K4   = 3'd4,
        SQ_K5   = 3'd5
    } seq_t;

    // Classification of one write cycle
    typedef struct packed {
        logic       key1;    // AAh at first key address
        logic       key2;    // 55h at second key address
        logic       at_cmd;  // address equals first key address
        logic [7:0] op;      // data byte
    } cyc_cls_t;

    // Completed commands, valid for one cycle
    typedef struct packed {
        logic prot_set;
        logic prot_clr;
        logic erase;
        logic id_enter;
        logic id_leave;
    } cmd_hit_t;

endpackage

// File: rtl/fcd_classify.sv
// Cycle classifier: compares the low CMP_W address bits and the data byte of
// one write against the unlock keys. Purely combinational; it assumes the
// caller passes only the address bits that take part in matching.
module fcd_classify
    import fcd_pkg::*;
#(
    parameter int CMP_W = 15
) (
    input  logic [CMP_W-1:0] addr,
    input  logic [7:0]       data,
    output cyc_cls_t         cls
);

    localparam logic [CMP_W-1:0] ADDR_1 = CMP_W'(KEY_ADDR_1);
    localparam logic [CMP_W-1:0] ADDR_2 = CMP_W'(KEY_ADDR_2);

    // Decode the key pattern of this cycle
    always_comb begin
        cls.at_cmd = (addr == ADDR_1);
        cls.key1   = (addr == ADDR_1) && (data == KEY_BYTE_1);
        cls.key2   = (addr == ADDR_2) && (data == KEY_BYTE_2);
        cls.op     = data;
    end

endmodule

// File: rtl/fcd_seq.sv
// Sequence tracker: follows the shared two-key opening and branches into the
// 3-cycle or 6-cycle commands. On a finished command it raises one hit flag
// for the current cycle. A write that breaks a sequence is released as data,
// unless it is itself an opening key, which restarts tracking.
// Assumes cyc_en is low whenever writes must bypass matching.
module fcd_seq
    import fcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_en,
    input  cyc_cls_t cls,
    output cmd_hit_t hit,
    output logic     consumed
);

    seq_t st, nxt;
    logic miss;

    // Next-state and command-completion decode
    always_comb begin
        nxt      = st;
        hit      = '0;
        consumed = 1'b0;
        miss     = 1'b0;
        if (cyc_en) begin
            consumed = 1'b1;
            nxt      = SQ_IDLE;
            case (st)
                SQ_IDLE: if (cls.key1) nxt = SQ_K1; else miss = 1'b1;
                SQ_K1:   if (cls.key2) nxt = SQ_K2; else miss = 1'b1;
                SQ_K2: begin
                    if (!cls.at_cmd) miss = 1'b1;
                    else begin
                        case (cls.op)
                            OP_PROT_SET: hit.prot_set = 1'b1;
                            OP_ID_SHORT: hit.id_enter = 1'b1;
                            OP_ID_LEAVE: hit.id_leave = 1'b1;
                            OP_EXTEND:   nxt = SQ_EXT;
                            default:     miss = 1'b1;
                        endcase
                    end
                end
                SQ_EXT:  if (cls.key1) nxt = SQ_K4; else miss = 1'b1;
                SQ_K4:   if (cls.key2) nxt = SQ_K5; else miss = 1'b1;
                SQ_K5: begin
                    if (!cls.at_cmd) miss = 1'b1;
                    else begin
                        case (cls.op)
                            OP_PROT_CLR: hit.prot_clr = 1'b1;
                            OP_ERASE:    hit.erase    = 1'b1;
                            OP_ID_LONG:  hit.id_enter = 1'b1;
                            default:     miss = 1'b1;
                        endcase
                    end
                end
                default: miss = 1'b1;
            endcase
            if (miss) begin
                if (cls.key1) nxt = SQ_K1;
                else          consumed = 1'b0;
            end
        end
    end

    // Tracker state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= nxt;
    end

    // R12: a broken sequence leaves the tracker idle or restarted
    a_r12_miss_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !consumed) |=> (st == SQ_IDLE));

    // R12: any tracker progress needs a write
    a_r12_progress_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en) |=> $stable(st));

endmodule

// File: rtl/fcd_prot.sv
// Software protection flag: set and cleared only by decoded commands.
// It has no reset on purpose. Its power-up value comes from PROT_INIT
// through a register initial value, which the target must support.
module fcd_prot #(
    parameter logic PROT_INIT = 1'b1
) (
    input  logic clk,
    input  logic set,
    input  logic clr,
    output logic on
);

    logic on_q = PROT_INIT;

    // Hold the flag across resets; set wins if both ever arrive together
    always_ff @(posedge clk) begin
        if (set)      on_q <= 1'b1;
        else if (clr) on_q <= 1'b0;
    end

    assign on = on_q;

endmodule

// File: rtl/fcd_gate.sv
// Load-window gate: decides which writes reach the page engine and keeps
// the load window. Assumes "consumed" is meaningful only while the window
// is closed, because the tracker is bypassed while it is open.
module fcd_gate #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              consumed,
    input  logic              prot_on,
    input  logic              open_req,
    input  logic              page_closed,
    output logic              load_open,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [7:0]        fwd_data
);

    logic data_wr, accept, open_nxt;

    // Classify the write as data and apply the protection gate
    always_comb begin
        data_wr  = wr_valid && (load_open || !consumed);
        accept   = data_wr && (load_open || !prot_on);
        open_nxt = (load_open && !page_closed) || open_req || (accept && !load_open);
    end

    // Window state and forward register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_open <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_addr  <= '0;
            fwd_data  <= '0;
        end else begin
            load_open <= open_nxt;
            fwd_valid <= accept;
            if (accept) begin
                fwd_addr <= wr_addr;
                fwd_data <= wr_data;
            end
        end
    end

    // R9: a forwarded write comes from a real bus write
    a_r9_fwd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(wr_valid));

    // R9: an open window with no close request stays open
    a_r9_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load_open && !page_closed) |=> load_open);

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the unlock command decoder. It classifies each bus write, tracks
// command sequences, keeps the persistent protection flag, gates data
// writes into load windows, and holds the identification mode and the
// erase pulse. All registered outputs change at the edge that samples the
// deciding write.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         CMP_W     = 15,
    parameter logic       PROT_INIT = 1'b1,
    parameter logic [7:0] MFR_CODE  = 8'hDA,
    parameter logic [7:0] DEV_CODE  = 8'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              page_closed,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              id_mode,
    output logic              erase_go,
    output logic              load_open,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [7:0]        fwd_data,
    output logic [7:0]        id_data
);

    localparam logic [ADDR_W-1:0] ID_ADDR_MFR = '0;
    localparam logic [ADDR_W-1:0] ID_ADDR_DEV = ADDR_W'(1);

    cyc_cls_t cls;
    cmd_hit_t hit;
    logic     consumed;
    logic     cyc_en;

    // Writes reach the tracker only outside a load window and out of reset
    assign cyc_en = rst_n && wr_valid && !load_open;

    fcd_classify #(.CMP_W(CMP_W)) u_cls (
        .addr (wr_addr[CMP_W-1:0]),
        .data (wr_data),
        .cls  (cls)
    );

    fcd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .cls      (cls),
        .hit      (hit),
        .consumed (consumed)
    );

    fcd_prot #(.PROT_INIT(PROT_INIT)) u_prot (
        .clk (clk),
        .set (hit.prot_set),
        .clr (hit.prot_clr),
        .on  (prot_on)
    );

    fcd_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .consumed    (consumed),
        .prot_on     (prot_on),
        .open_req    (hit.prot_set),
        .page_closed (page_closed),
        .load_open   (load_open),
        .fwd_valid   (fwd_valid),
        .fwd_addr    (fwd_addr),
        .fwd_data    (fwd_data)
    );

    // Identification mode and erase start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mode  <= 1'b0;
            erase_go <= 1'b0;
        end else begin
            erase_go <= hit.erase;
            if (hit.id_enter)      id_mode <= 1'b1;
            else if (hit.id_leave) id_mode <= 1'b0;
        end
    end

    // Identification byte for the read multiplexer
    always_comb begin
        if (!id_mode)                 id_data = 8'h00;
        else if (rd_addr == ID_ADDR_MFR) id_data = MFR_CODE;
        else if (rd_addr == ID_ADDR_DEV) id_data = DEV_CODE;
        else                          id_data = 8'h00;
    end

    // R5: erase start is a single-cycle pulse
    a_r5_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);

    // R5: erase start follows a write carrying the erase byte
    a_r5_erase_cause: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> $past(wr_valid && wr_data == OP_ERASE));

    // R8: forwarding only when unprotected or inside a window
    a_r8_fwd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(load_open || !prot_on));

    // R4: protection drops only on a write of the clear byte
    a_r4_prot_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_valid && wr_data == OP_PROT_CLR));

    // R3: protection rises with the set byte and opens the window
    a_r3_prot_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> ($past(wr_valid && wr_data == OP_PROT_SET) && load_open));

    // R6: identification mode changes only on a write
    a_r6_id_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> $past(wr_valid));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

    localparam int K1 = 'h5555AA;
    localparam int K2 = 'h2AAA55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_closed = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        prot_on, id_mode, erase_go, load_open, fwd_valid;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data, id_data;

    int n_chk = 0;
    int n_err = 0;

    // Behavioural reference state
    bit          m_prot = 1'b1;
    bit          m_id, m_open, m_erase, m_fv;
    logic [15:0] m_fa;
    logic [7:0]  m_fd;
    int          hist[$];

    int lens[6] = '{3, 3, 3, 6, 6, 6};
    int cmds[6][6] = '{
        '{K1, K2, 'h5555A0, 0, 0, 0},
        '{K1, K2, 'h555590, 0, 0, 0},
        '{K1, K2, 'h5555F0, 0, 0, 0},
        '{K1, K2, 'h555580, K1, K2, 'h555520},
        '{K1, K2, 'h555580, K1, K2, 'h555510},
        '{K1, K2, 'h555580, K1, K2, 'h555560}
    };

    always #2 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .page_closed(page_closed), .rd_addr(rd_addr),
        .prot_on(prot_on), .id_mode(id_mode), .erase_go(erase_go),
        .load_open(load_open), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .fwd_data(fwd_data), .id_data(id_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void match(input int q[$], output int full_idx, output bit is_pre);
        bit ok;
        full_idx = -1;
        is_pre   = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (q.size() <= lens[k]) begin
                ok = 1'b1;
                for (int i = 0; i < q.size(); i++)
                    if (q[i] != cmds[k][i]) ok = 1'b0;
                if (ok) begin
                    if (q.size() == lens[k]) full_idx = k;
                    else is_pre = 1'b1;
                end
            end
        end
    endfunction

    task automatic model_step(input bit v, input logic [15:0] a, input logic [7:0] d, input bit pc);
        bit nopen, fv, pre;
        int key, fi;
        int cand[$];
        if (!rst_n) begin
            m_id = 0; m_open = 0; m_erase = 0; m_fv = 0;
            hist.delete();
            return;
        end
        nopen   = m_open && !pc;
        fv      = 1'b0;
        m_erase = 1'b0;
        if (v) begin
            if (m_open) fv = 1'b1;
            else begin
                key  = (int'(a[14:0]) << 8) | int'(d);
                cand = hist;
                cand.push_back(key);
                match(cand, fi, pre);
                if (fi >= 0) begin
                    hist.delete();
                    case (fi)
                        0: begin m_prot = 1'b1; nopen = 1'b1; end
                        1, 5: m_id = 1'b1;
                        2: m_id = 1'b0;
                        3: m_prot = 1'b0;
                        4: m_erase = 1'b1;
                        default: ;
                    endcase
                end else if (pre) begin
                    hist = cand;
                end else begin
                    hist.delete();
                    if (key == K1) hist.push_back(key);
                    else if (!m_prot) begin fv = 1'b1; nopen = 1'b1; end
                end
            end
        end
        m_open = nopen;
        m_fv   = fv;
        if (fv) begin m_fa = a; m_fd = d; end
    endtask

    task automatic compare_all();
        int exp_id;
        check("R4 prot_on", prot_on, m_prot);
        check("R6 id_mode", id_mode, m_id);
        check("R5 erase_go", erase_go, m_erase);
        check("R9 load_open", load_open, m_open);
        check("R8 fwd_valid", fwd_valid, m_fv);
        if (m_fv) begin
            check("R9 fwd_addr", fwd_addr, m_fa);
            check("R9 fwd_data", fwd_data, m_fd);
        end
        exp_id = !m_id ? 0 : (rd_addr == 0) ? 'hDA : (rd_addr == 1) ? 'hC8 : 0;
        check("R7 id_data", id_data, exp_id);
    endtask

    // One clock: drive after a falling edge, sample at the next falling edge
    task automatic cyc(input bit v, input logic [15:0] a, input logic [7:0] d, input bit pc);
        wr_valid = v; wr_addr = a; wr_data = d; page_closed = pc;
        model_step(v, a, d, pc);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 16'h0, 8'h0, 1'b0);
    endtask

    task automatic close_win();
        cyc(1'b0, 16'h0, 8'h0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) idle();
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1, R2: reset state
        check("R1 id_mode after reset", id_mode, 0);
        check("R1 load_open after reset", load_open, 0);
        check("R1 fwd_valid after reset", fwd_valid, 0);
        check("R2 prot_on at power-up", prot_on, 1);

        // R8: protected, no window -> discarded
        wr(16'h0123, 8'h5A);
        check("R8 discarded write", fwd_valid, 0);

        // R3: enable sequence opens a window
        wr(16'h5555, 8'hAA);
        check("R3 key not forwarded", fwd_valid, 0);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
        check("R3 prot set", prot_on, 1);
        check("R3 window open", load_open, 1);
        check("R3 op not forwarded", fwd_valid, 0);
        // R9: window passes everything, including key patterns
        wr(16'h0040, 8'h11);
        check("R9 data forwarded", fwd_data, 8'h11);
        wr(16'h5555, 8'hAA);
        check("R9 key inside window forwarded", fwd_valid, 1);
        wr(16'h0041, 8'h22);
        close_win();
        check("R9 window closed", load_open, 0);

        // R6, R7: short identification entry and codes
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
        check("R6 short entry", id_mode, 1);
        rd_addr = 16'h0000; idle();
        check("R7 manufacturer code", id_data, 8'hDA);
        rd_addr = 16'h0001; idle();
        check("R7 device code", id_data, 8'hC8);
        rd_addr = 16'h0002; idle();
        check("R7 other address", id_data, 8'h00);
        rd_addr = 16'h0000;
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hF0);
        check("R6 exit", id_mode, 0);
        // R6: long entry, then reset clears it while protection stays
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h60);
        check("R6 long entry", id_mode, 1);
        do_reset();
        check("R6 reset clears id", id_mode, 0);

        // R5: chip erase pulse
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
        check("R5 erase pulse high", erase_go, 1);
        idle();
        check("R5 erase pulse one cycle", erase_go, 0);

        // R12: broken sequence, then a lone A0 does nothing
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h1234, 8'h77);
        check("R12 mismatch discarded while protected", fwd_valid, 0);
        wr(16'h5555, 8'hA0);
        check("R12 lone op ignored", load_open, 0);
        // R12: repeated opening key restarts the sequence
        wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
        check("R12 restart opens window", load_open, 1);
        close_win();

        // R4: disable protection; R2: reset keeps it cleared
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h20);
        check("R4 prot cleared", prot_on, 0);
        check("R4 no window", load_open, 0);
        do_reset();
        check("R2 reset keeps prot", prot_on, 0);

        // R10, R12: unprotected mismatch becomes data and opens window
        wr(16'h5555, 8'hAA); wr(16'h1000, 8'h3C);
        check("R10 unprotected data forwarded", fwd_valid, 1);
        check("R12 mismatched byte as data", fwd_data, 8'h3C);
        check("R10 window opened", load_open, 1);
        close_win();

        // R11: bit 15 ignored in matching
        wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'hA0);
        check("R11 high bit ignored", prot_on, 1);
        close_win();
        idle();

        summary();
        $finish;
    end

endmodule